// File: doc/BRIEF.md
# Byte Stream Video Register Command Decoder

This block takes a byte-wide command stream, for instance the payload of a bulk transfer from a host, and turns it into writes to a small video register file and into pixel copy requests. Bytes arrive through a valid/ready handshake. Each command opens with a prefix byte and an opcode. Two opcodes are understood: a four-byte register write and a nine-byte copy. Every other byte sequence is thrown away while the parser looks for the next prefix.

Display timing registers (indexes 0x00 to 0x1F, with 0x00 being the colour depth select, 0 meaning 16 bits per pixel) are double-buffered. While the bank is locked, writes land in shadow copies only. The unlock write moves every shadow copy into the active set in a single cycle, so the timing generator never sees a partly updated mode. The two segment base pointers and the blank-mode register are not shadowed. Each accepted register write is also sent out on a write port. Copy requests leave through a valid/ready output, and the input stalls while one is pending.

The parser is a state machine with eight states. ST_HUNT drops bytes until it sees the prefix and then moves to ST_OPCODE. In ST_OPCODE, opcode 0x20 leads to ST_WIDX, opcode 0x6A leads to ST_CSRC, another prefix stays in ST_OPCODE, and any other byte returns to ST_HUNT. ST_WIDX captures the index and moves to ST_WVAL. ST_WVAL captures the value, issues the write and returns to ST_HUNT. ST_CSRC takes the source address bytes and moves to ST_CCNT. ST_CCNT takes the pixel count and moves to ST_CDST. ST_CDST takes the destination bytes and moves to ST_CISSUE. ST_CISSUE holds the request until the consumer accepts it and then returns to ST_HUNT.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset, in_ready is 1, reg_we and copy_valid are 0, bank_locked is 0, and base16, base8, blank_mode and every timing register read through cfg_val are zero.
- R2: While the parser is waiting for a command, every byte other than the prefix 0xAF is dropped: it causes no register write and no copy request.
- R3: The sequence 0xAF, 0x20, index, value produces exactly one reg_we pulse carrying that index and value. The pulse is high in the cycle right after the value byte is accepted.
- R4: An opcode byte other than 0x20, 0x6A or 0xAF is dropped and the parser goes back to waiting for a prefix. A prefix in the opcode position counts as a fresh prefix, so a lone 0xAF that ends a transfer has no side effect.
- R5: A write of 0x00 to index 0xFF sets bank_locked. While the bank is locked, writes to indexes 0x00 to 0x1F change only the shadow copies, and cfg_val keeps showing the old active values.
- R6: A write of 0xFF to index 0xFF clears bank_locked and copies every shadow register into the active set at one clock edge. Any other value written to index 0xFF has no effect.
- R7: While the bank is unlocked, a write to an index from 0x00 to 0x1F updates the active register that cfg_val shows, one cycle after the reg_we pulse.
- R8: Indexes 0x20, 0x21 and 0x22 set the bytes of base16, and indexes 0x26, 0x27 and 0x28 set the bytes of base8, in both cases most significant byte first. These writes take effect at once whatever the lock state.
- R9: Index 0x30 sets blank_mode at once whatever the lock state.
- R10: The sequence 0xAF, 0x6A, a 3-byte source address, a 1-byte pixel count and a 3-byte destination address (both addresses most significant byte first) raises copy_valid in the cycle right after the last byte is accepted, with copy_src, copy_count and copy_dst holding those fields.
- R11: While copy_valid is high, in_ready is 0 and the copy fields hold steady. After the cycle in which copy_valid and copy_ready are both high, the parser goes back to waiting for a prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can accept a byte |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | 8 | Register write index |
| reg_data | output | 8 | Register write value |
| copy_valid | output | 1 | Copy request pending |
| copy_ready | input | 1 | Copy request accepted |
| copy_src | output | 24 | Copy source address |
| copy_count | output | 8 | Copy pixel count |
| copy_dst | output | 24 | Copy destination address |
| bank_locked | output | 1 | Timing register bank locked |
| cfg_idx | input | 5 | Timing register read index |
| cfg_val | output | 8 | Active timing register value |
| base16 | output | 24 | 16bpp segment base |
| base8 | output | 24 | 8bpp segment base |
| blank_mode | output | 8 | Blank mode value |

## Verification
A register write strobe is due in the single cycle after its value byte is accepted. The register state it changes becomes visible one cycle later still. A copy request is due in the cycle after its last destination byte is accepted. The bench records the cycle in which each final byte is accepted, queues the write or copy it expects with that due cycle, and compares the outputs on every clock. Any strobe that arrives early, late, unexpected or with the wrong contents is reported. Register state is read back through the read port and the parallel outputs only after the update edge has passed.

// File: rtl/csd_pkg.sv
package csd_pkg;
    localparam logic [7:0] PREFIX    = 8'hAF;
    localparam logic [7:0] OP_WREG   = 8'h20;
    localparam logic [7:0] OP_COPY   = 8'h6A;
    localparam logic [7:0] IDX_LOCK  = 8'hFF;
    localparam logic [7:0] LOCK_ON   = 8'h00;
    localparam logic [7:0] LOCK_OFF  = 8'hFF;
    localparam logic [7:0] IDX_B16   = 8'h20;
    localparam logic [7:0] IDX_B8    = 8'h26;
    localparam logic [7:0] IDX_BLANK = 8'h30;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_OPCODE,
        ST_WIDX,
        ST_WVAL,
        ST_CSRC,
        ST_CCNT,
        ST_CDST,
        ST_CISSUE
    } pstate_e;
endpackage

// File: rtl/csd_parser.sv
module csd_parser
    import csd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              wr_en,
    output logic [7:0]        wr_idx,
    output logic [7:0]        wr_val,
    output logic              cp_valid,
    input  logic              cp_ready,
    output logic [ADDR_W-1:0] cp_src,
    output logic [7:0]        cp_cnt,
    output logic [ADDR_W-1:0] cp_dst
);
    localparam int AB = ADDR_W / 8;
    localparam int CW = (AB > 1) ? $clog2(AB) : 1;
    localparam logic [CW-1:0] LAST = CW'(AB - 1);

    pstate_e       state, nxt;
    logic [CW-1:0] bcnt;
    logic          acc;

    assign in_ready = (state != ST_CISSUE);
    assign acc      = in_valid && in_ready;
    assign cp_valid = (state == ST_CISSUE);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:   if (acc && in_data == PREFIX) nxt = ST_OPCODE;
            ST_OPCODE: if (acc) begin
                if (in_data == OP_WREG)      nxt = ST_WIDX;
                else if (in_data == OP_COPY) nxt = ST_CSRC;
                else if (in_data == PREFIX)  nxt = ST_OPCODE;
                else                         nxt = ST_HUNT;
            end
            ST_WIDX:   if (acc) nxt = ST_WVAL;
            ST_WVAL:   if (acc) nxt = ST_HUNT;
            ST_CSRC:   if (acc && bcnt == LAST) nxt = ST_CCNT;
            ST_CCNT:   if (acc) nxt = ST_CDST;
            ST_CDST:   if (acc && bcnt == LAST) nxt = ST_CISSUE;
            ST_CISSUE: if (cp_ready) nxt = ST_HUNT;
            default:   nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en  <= 1'b0;
            wr_idx <= '0;
            wr_val <= '0;
            bcnt   <= '0;
            cp_src <= '0;
            cp_cnt <= '0;
            cp_dst <= '0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                ST_OPCODE: bcnt <= '0;
                ST_WIDX:   if (acc) wr_idx <= in_data;
                ST_WVAL:   if (acc) begin
                    wr_val <= in_data;
                    wr_en  <= 1'b1;
                end
                ST_CSRC:   if (acc) begin
                    cp_src <= (AB > 1) ? {cp_src[ADDR_W-9:0], in_data} : ADDR_W'(in_data);
                    bcnt   <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
                end
                ST_CCNT:   if (acc) cp_cnt <= in_data;
                ST_CDST:   if (acc) begin
                    cp_dst <= (AB > 1) ? {cp_dst[ADDR_W-9:0], in_data} : ADDR_W'(in_data);
                    bcnt   <= (bcnt == LAST) ? '0 : bcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/csd_vregs.sv
module csd_vregs
    import csd_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int NREG   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_idx,
    input  logic [7:0]              wr_val,
    output logic                    locked,
    input  logic [$clog2(NREG)-1:0] rd_idx,
    output logic [7:0]              rd_val,
    output logic [ADDR_W-1:0]       base16,
    output logic [ADDR_W-1:0]       base8,
    output logic [7:0]              blank
);
    localparam int AB = ADDR_W / 8;

    logic [7:0] act_q [NREG];
    logic [7:0] shd_q [NREG];
    logic       commit;

    assign commit = wr_en && wr_idx == IDX_LOCK && wr_val == LOCK_OFF;
    assign rd_val = act_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked <= 1'b0;
            base16 <= '0;
            base8  <= '0;
            blank  <= '0;
            for (int i = 0; i < NREG; i++) begin
                act_q[i] <= '0;
                shd_q[i] <= '0;
            end
        end else begin
            if (wr_en && wr_idx == IDX_LOCK) begin
                if (wr_val == LOCK_ON)  locked <= 1'b1;
                if (wr_val == LOCK_OFF) locked <= 1'b0;
            end
            for (int i = 0; i < NREG; i++) begin
                if (commit)
                    act_q[i] <= shd_q[i];
                else if (wr_en && !locked && wr_idx == 8'(i))
                    act_q[i] <= wr_val;
                if (wr_en && wr_idx == 8'(i))
                    shd_q[i] <= wr_val;
            end
            for (int b = 0; b < AB; b++) begin
                if (wr_en && wr_idx == IDX_B16 + 8'(b))
                    base16[ADDR_W-1-8*b -: 8] <= wr_val;
                if (wr_en && wr_idx == IDX_B8 + 8'(b))
                    base8[ADDR_W-1-8*b -: 8] <= wr_val;
            end
            if (wr_en && wr_idx == IDX_BLANK) blank <= wr_val;
        end
    end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder #(
    parameter int ADDR_W = 24,
    parameter int NREG   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_data,
    output logic                    in_ready,
    output logic                    reg_we,
    output logic [7:0]              reg_addr,
    output logic [7:0]              reg_data,
    output logic                    copy_valid,
    input  logic                    copy_ready,
    output logic [ADDR_W-1:0]       copy_src,
    output logic [7:0]              copy_count,
    output logic [ADDR_W-1:0]       copy_dst,
    output logic                    bank_locked,
    input  logic [$clog2(NREG)-1:0] cfg_idx,
    output logic [7:0]              cfg_val,
    output logic [ADDR_W-1:0]       base16,
    output logic [ADDR_W-1:0]       base8,
    output logic [7:0]              blank_mode
);
    csd_parser #(.ADDR_W(ADDR_W)) u_parser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .wr_en    (reg_we),
        .wr_idx   (reg_addr),
        .wr_val   (reg_data),
        .cp_valid (copy_valid),
        .cp_ready (copy_ready),
        .cp_src   (copy_src),
        .cp_cnt   (copy_count),
        .cp_dst   (copy_dst)
    );

    csd_vregs #(.ADDR_W(ADDR_W), .NREG(NREG)) u_vregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .wr_idx (reg_addr),
        .wr_val (reg_data),
        .locked (bank_locked),
        .rd_idx (cfg_idx),
        .rd_val (cfg_val),
        .base16 (base16),
        .base8  (base8),
        .blank  (blank_mode)
    );
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              reg_we,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_data,
    input logic              copy_valid,
    input logic              copy_ready,
    input logic [ADDR_W-1:0] copy_src,
    input logic [7:0]        copy_count,
    input logic [ADDR_W-1:0] copy_dst,
    input logic              bank_locked,
    input logic [ADDR_W-1:0] base16
);
    // R11
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> !in_ready);
    // R11
    copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid && !copy_ready |=> copy_valid && $stable(copy_src)
                                      && $stable(copy_count) && $stable(copy_dst));
    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
    // R5
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == 8'hFF && reg_data == 8'h00 |=> bank_locked);
    // R6
    unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == 8'hFF && reg_data == 8'hFF |=> !bank_locked);
    // R6
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 8'hFF) |=> bank_locked == $past(bank_locked));
    // R8
    base_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_addr == 8'h20 |=> base16[ADDR_W-1 -: 8] == $past(reg_data));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmd_stream_decoder_test.sv
`timescale 1ns/100ps
module cmd_stream_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        reg_we;
    logic [7:0]  reg_addr, reg_data;
    logic        copy_valid;
    logic        copy_ready = 1'b1;
    logic [23:0] copy_src, copy_dst;
    logic [7:0]  copy_count;
    logic        bank_locked;
    logic [4:0]  cfg_idx = '0;
    logic [7:0]  cfg_val;
    logic [23:0] base16, base8;
    logic [7:0]  blank_mode;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // behavioural model state
    int m_act [32];
    int m_shd [32];
    bit m_locked = 0;
    int m_b16 = 0, m_b8 = 0, m_blank = 0;
    int q_idx[$], q_val[$], q_due[$];
    int c_src[$], c_cnt[$], c_dst[$], c_due[$];
    bit prev_cv = 0;

    cmd_stream_decoder uut (.*);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (reg_we) begin
                if (q_idx.size() == 0) check(0, "R2 R4 unexpected write", reg_addr, 0);
                else begin
                    check(q_due[0] == cyc, "R3 write cycle", cyc, q_due[0]);
                    check(reg_addr == q_idx[0] && reg_data == q_val[0], "R3 write contents",
                          {reg_addr, reg_data}, {q_idx[0][7:0], q_val[0][7:0]});
                    if (q_idx[0] == 'hFF) begin
                        if (q_val[0] == 0) m_locked = 1;
                        if (q_val[0] == 'hFF) begin
                            m_locked = 0;
                            for (int i = 0; i < 32; i++) m_act[i] = m_shd[i];
                        end
                    end else if (q_idx[0] < 32) begin
                        m_shd[q_idx[0]] = q_val[0];
                        if (!m_locked) m_act[q_idx[0]] = q_val[0];
                    end else if (q_idx[0] >= 'h20 && q_idx[0] <= 'h22)
                        m_b16[23-8*(q_idx[0]-'h20) -: 8] = q_val[0];
                    else if (q_idx[0] >= 'h26 && q_idx[0] <= 'h28)
                        m_b8[23-8*(q_idx[0]-'h26) -: 8] = q_val[0];
                    else if (q_idx[0] == 'h30) m_blank = q_val[0];
                    void'(q_idx.pop_front()); void'(q_val.pop_front()); void'(q_due.pop_front());
                end
            end
            if (copy_valid) begin
                check(!in_ready, "R11 stall", in_ready, 0);
                if (c_src.size() == 0) check(0, "R2 R4 unexpected copy", copy_src, 0);
                else begin
                    if (!prev_cv) check(c_due[0] == cyc, "R10 copy cycle", cyc, c_due[0]);
                    if (copy_ready) begin
                        check(copy_src == c_src[0], "R10 src", copy_src, c_src[0]);
                        check(copy_count == c_cnt[0], "R10 count", copy_count, c_cnt[0]);
                        check(copy_dst == c_dst[0], "R10 dst", copy_dst, c_dst[0]);
                        void'(c_src.pop_front()); void'(c_cnt.pop_front());
                        void'(c_dst.pop_front()); void'(c_due.pop_front());
                    end
                end
            end
            prev_cv = copy_valid;
        end
    end

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input int val);
        send(8'hAF); send(8'h20); send(8'(idx)); send(8'(val));
        q_idx.push_back(idx); q_val.push_back(val); q_due.push_back(cyc);
    endtask

    task automatic cp(input int s, input int n, input int d, input int hold);
        copy_ready = (hold == 0);
        send(8'hAF); send(8'h6A);
        for (int k = 2; k >= 0; k--) send(8'(s >> (8*k)));
        send(8'(n));
        for (int k = 2; k >= 0; k--) send(8'(d >> (8*k)));
        c_src.push_back(s); c_cnt.push_back(n); c_dst.push_back(d); c_due.push_back(cyc);
        repeat (hold) @(negedge clk);
        copy_ready = 1'b1;
        while (copy_valid) @(negedge clk);
        @(negedge clk);
        check(in_ready, "R11 ready after copy", in_ready, 1);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic state_chk(input string req);
        @(negedge clk); #2;
        check(bank_locked == m_locked, req, bank_locked, m_locked);
        check(base16 == 24'(m_b16), "R8 base16", base16, m_b16);
        check(base8 == 24'(m_b8), "R8 base8", base8, m_b8);
        check(blank_mode == 8'(m_blank), "R9 blank", blank_mode, m_blank);
        for (int i = 0; i < 32; i++) begin
            cfg_idx = 5'(i);
            #0.1;
            check(cfg_val == 8'(m_act[i]), req, cfg_val, m_act[i]);
        end
    endtask

    initial begin
        #1000000;
        check(0, "watchdog", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_act[i] = 0; m_shd[i] = 0; end
        repeat (4) @(negedge clk);
        // R1 reset state
        check(in_ready && !reg_we && !copy_valid, "R1 reset outputs",
              {in_ready, reg_we, copy_valid}, 3'b100);
        rst_n = 1'b1;
        state_chk("R1 reset registers");
        // R2 junk while hunting
        send(8'h00); send(8'h20); send(8'h6A); send(8'h11);
        idle(3); state_chk("R2 junk dropped");
        // R3 R7 unlocked writes
        wr('h05, 'h3C); wr('h00, 'h01); wr('h1F, 'hA5);
        idle(2); state_chk("R7 direct write");
        // R4 unknown opcode then stray bytes
        send(8'hAF); send(8'h55); send(8'h20); send(8'h01); send(8'h02);
        idle(3); state_chk("R4 unknown opcode");
        // R4 doubled prefix
        send(8'hAF);
        wr('h06, 'h77);
        idle(2); state_chk("R4 doubled prefix");
        // R5 lock and shadow writes
        wr('hFF, 'h00);
        wr('h05, 'h99); wr('h10, 'h42); wr('h00, 'h00);
        idle(2); state_chk("R5 shadow hold");
        // R8 R9 immediate while locked
        wr('h20, 'h12); wr('h21, 'h34); wr('h22, 'h56);
        wr('h26, 'hAB); wr('h27, 'hCD); wr('h28, 'hEF);
        wr('h30, 'h03);
        idle(2); state_chk("R8 R9 immediate");
        // R6 other value to lock index ignored
        wr('hFF, 'h12);
        idle(2); state_chk("R6 ignored value");
        // R6 unlock commits
        wr('hFF, 'hFF);
        idle(1); state_chk("R6 commit");
        // R10 copy, immediate accept
        cp('h000000, 'h01, 'h000000, 0);
        // R10 R11 copy with stalled consumer, then a write queued behind it
        cp('h123456, 'h20, 'hABCDEF, 4);
        wr('h07, 'h5A);
        idle(2); state_chk("R11 resume");
        // R4 lone trailing prefix
        send(8'hAF);
        idle(5); state_chk("R4 lone terminator");
        idle(3);
        check(q_idx.size() == 0, "R3 pending writes", q_idx.size(), 0);
        check(c_src.size() == 0, "R10 pending copies", c_src.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule